// File: doc/BRIEF.md
# Dual-Write Dual-Read Register File

This block is a small register file of sixteen 8-bit registers. Two write ports and two read ports share one clock. Each write port has its own data, a 4-bit target select and an enable. Both write ports can commit on the same rising edge. When both write ports name the same register, write port 1 takes priority. Each read port has a 4-bit select, and its output follows the contents of the selected register combinationally.

A typical user is a small datapath that retires two results per cycle and reads two operands per cycle. A synchronous active-high reset clears every register to zero. There is no forwarding from a write port to a read port inside the same cycle. A read shows the new value only after the edge that stores it.

Top module: `regfile_2w2r`

## Requirements
- R1: Clearing: while `rst` is high at a rising edge, all sixteen registers become zero, so after reset every select on either read port returns 0x00.
- R2: A write port whose enable is high at a rising edge stores its 8-bit data in the register whose index is the binary value of its 4-bit select (0 to 15). Each write port does this on its own.
- R3: A write port whose enable is low at a rising edge changes no register, whatever its data and select carry.
- R4: When both enables are high and the two selects differ, both target registers take their new values on the same edge.
- R5: When both enables are high and the selects are equal, the register takes write port 1's data and write port 2's data is lost.
- R6: A register that neither port writes keeps its value across any number of edges.
- R7: Each read output equals the current contents of the register its select names, with no clock delay. A register being written shows its old value until the edge and its new value right after it.
- R8: Both read ports may name the same register, or the register being written, at once, and each still returns that register's contents.
- R9: Reset has priority over writes: with `rst` high, an edge clears the targets of enabled write ports too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| wa_en | input | 1 | Write port 1 enable (priority port) |
| wa_sel | input | 4 | Write port 1 target register index |
| wa_data | input | 8 | Write port 1 data |
| wb_en | input | 1 | Write port 2 enable |
| wb_sel | input | 4 | Write port 2 target register index |
| wb_data | input | 8 | Write port 2 data |
| ra_sel | input | 4 | Read port A register index |
| ra_data | output | 8 | Read port A data |
| rb_sel | input | 4 | Read port B register index |
| rb_data | output | 8 | Read port B data |

## Verification
The write logic is tried with single writes on each port alone, which separates the two decode paths, and with writes whose enable is low, which shows that the enable gates the store. It is also tried with dual writes to different registers, including the end indices 0 and 15, which shows that both ports commit at once. Dual writes to one register show that port 1 wins in both orders of data values. Reads taken before and after a write edge show that there is no same-cycle forwarding. A reset asserted during active writes shows that clearing beats storing.

// File: rtl/dwrf_pkg.sv
package dwrf_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned ADDR_W_DEF = 4;
endpackage

// File: rtl/dwrf_steer.sv
module dwrf_steer #(
  parameter int unsigned ADDR_W = dwrf_pkg::ADDR_W_DEF,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_sel,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_sel,
  output logic [DEPTH-1:0]  load,
  output logic [DEPTH-1:0]  pick_a
);
  // Per-entry decode: port 1 hit overrides port 2 on the data source.
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic hit_a, hit_b;
    assign hit_a     = wa_en && (wa_sel == ADDR_W'(i));
    assign hit_b     = wb_en && (wb_sel == ADDR_W'(i));
    assign load[i]   = hit_a || hit_b;
    assign pick_a[i] = hit_a;
  end
endmodule

// File: rtl/dwrf_store.sv
module dwrf_store #(
  parameter int unsigned DATA_W = dwrf_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W = dwrf_pkg::ADDR_W_DEF,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wa_en,
  input  logic [ADDR_W-1:0]       wa_sel,
  input  logic [DATA_W-1:0]       wa_data,
  input  logic                    wb_en,
  input  logic [ADDR_W-1:0]       wb_sel,
  input  logic [DATA_W-1:0]       wb_data,
  input  logic [DEPTH-1:0]        load,
  input  logic [DEPTH-1:0]        pick_a,
  output logic [DEPTH*DATA_W-1:0] flat
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_reg
    logic [DATA_W-1:0] nxt;
    assign nxt = pick_a[i] ? wa_data : wb_data;
    always_ff @(posedge clk) begin
      if (rst)          mem[i] <= '0;
      else if (load[i]) mem[i] <= nxt;
    end
    assign flat[i*DATA_W +: DATA_W] = mem[i];
  end

  AST_PORT1_STORES: assert property (@(posedge clk) disable iff (rst)
    wa_en |=> mem[$past(wa_sel)] == $past(wa_data)); // R5
  AST_PORT2_STORES: assert property (@(posedge clk) disable iff (rst)
    (wb_en && !(wa_en && wa_sel == wb_sel)) |=> mem[$past(wb_sel)] == $past(wb_data)); // R4
  AST_AT_MOST_TWO_LOADS: assert property (@(posedge clk) disable iff (rst)
    $countones(load) <= 2); // R4
  AST_COLLIDE_ONE_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wa_en && wb_en && wa_sel == wb_sel) |-> $onehot0(load) && (load == pick_a)); // R5
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!wa_en && !wb_en) |-> load == '0); // R3
endmodule

// File: rtl/dwrf_rdmux.sv
module dwrf_rdmux #(
  parameter int unsigned DATA_W = dwrf_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W = dwrf_pkg::ADDR_W_DEF,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic [DEPTH*DATA_W-1:0] flat,
  input  logic [ADDR_W-1:0]       sel,
  output logic [DATA_W-1:0]       dout
);
  assign dout = flat[sel*DATA_W +: DATA_W];
endmodule

// File: rtl/regfile_2w2r.sv
module regfile_2w2r #(
  parameter int unsigned DATA_W = dwrf_pkg::DATA_W_DEF,
  parameter int unsigned ADDR_W = dwrf_pkg::ADDR_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wa_en,
  input  logic [ADDR_W-1:0] wa_sel,
  input  logic [DATA_W-1:0] wa_data,
  input  logic              wb_en,
  input  logic [ADDR_W-1:0] wb_sel,
  input  logic [DATA_W-1:0] wb_data,
  input  logic [ADDR_W-1:0] ra_sel,
  output logic [DATA_W-1:0] ra_data,
  input  logic [ADDR_W-1:0] rb_sel,
  output logic [DATA_W-1:0] rb_data
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned NRD   = 2;

  logic [DEPTH-1:0]        load, pick_a;
  logic [DEPTH*DATA_W-1:0] flat;
  logic [ADDR_W-1:0]       rsel [NRD];
  logic [DATA_W-1:0]       rdat [NRD];

  dwrf_steer #(.ADDR_W(ADDR_W)) u_steer (
    .wa_en(wa_en), .wa_sel(wa_sel), .wb_en(wb_en), .wb_sel(wb_sel),
    .load(load), .pick_a(pick_a)
  );

  dwrf_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_sel(wa_sel), .wa_data(wa_data),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .load(load), .pick_a(pick_a), .flat(flat)
  );

  assign rsel[0] = ra_sel;
  assign rsel[1] = rb_sel;

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    dwrf_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
      .flat(flat), .sel(rsel[p]), .dout(rdat[p])
    );
  end

  assign ra_data = rdat[0];
  assign rb_data = rdat[1];

  AST_SAME_SEL_SAME_DATA: assert property (@(posedge clk) disable iff (rst)
    (ra_sel == rb_sel) |-> ra_data == rb_data); // R8
  AST_UNTOUCHED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!(wa_en && wa_sel == ra_sel) && !(wb_en && wb_sel == ra_sel))
      |=> ($stable(ra_sel) -> $stable(ra_data))); // R6
  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk)
    $past(rst) |-> (ra_data == '0 && rb_data == '0)); // R1
endmodule

// File: tb/tb_regfile_2w2r.sv
module tb_regfile_2w2r;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wa_en = 1'b0, wb_en = 1'b0;
  logic [3:0] wa_sel = '0, wb_sel = '0, ra_sel = '0, rb_sel = '0;
  logic [7:0] wa_data = '0, wb_data = '0;
  logic [7:0] ra_data, rb_data;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  regfile_2w2r dut (
    .clk(clk), .rst(rst),
    .wa_en(wa_en), .wa_sel(wa_sel), .wa_data(wa_data),
    .wb_en(wb_en), .wb_sel(wb_sel), .wb_data(wb_data),
    .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_sel(rb_sel), .rb_data(rb_data)
  );

  // {wa_en,wa_sel,wa_data, wb_en,wb_sel,wb_data, ra_sel,rb_sel, expA,expB}
  localparam logic [49:0] VEC [NVEC] = '{
    {1'b1,4'h0,8'hF0, 1'b0,4'h0,8'h00, 4'h0,4'h1, 8'hF0,8'h00}, // R2 port 1 alone
    {1'b1,4'h8,8'hF1, 1'b0,4'h3,8'hAA, 4'h8,4'h3, 8'hF1,8'h00}, // R3 port 2 disabled
    {1'b0,4'h5,8'h55, 1'b0,4'h6,8'h66, 4'h0,4'h8, 8'hF0,8'hF1}, // R6 hold, R3
    {1'b1,4'h0,8'h12, 1'b1,4'h1,8'h34, 4'h0,4'h1, 8'h12,8'h34}, // R4 distinct
    {1'b1,4'h0,8'hFF, 1'b1,4'h0,8'h00, 4'h0,4'h0, 8'hFF,8'hFF}, // R5 collide, R8
    {1'b1,4'hF,8'hA5, 1'b1,4'hE,8'h5A, 4'hF,4'hE, 8'hA5,8'h5A}, // R4 top indices
    {1'b0,4'hF,8'h00, 1'b1,4'hF,8'h3C, 4'hF,4'h8, 8'h3C,8'hF1}, // R2 port 2 alone
    {1'b1,4'h7,8'h77, 1'b1,4'h7,8'h88, 4'h7,4'hF, 8'h77,8'h3C}, // R5 collide
    {1'b0,4'h0,8'h00, 1'b0,4'h0,8'h00, 4'h1,4'hE, 8'h34,8'h5A}  // R6 hold
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1: all registers cleared after reset
    for (int i = 0; i < 16; i++) begin
      ra_sel = 4'(i); rb_sel = 4'(15 - i);
      #1;
      check("R1 read A", ra_data, 8'h00);
      check("R1 read B", rb_data, 8'h00);
    end

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      {wa_en, wa_sel, wa_data, wb_en, wb_sel, wb_data, ra_sel, rb_sel} = VEC[v][49:16];
      @(posedge clk); #2;
      check($sformatf("R2-R8 vec%0d A", v), ra_data, VEC[v][15:8]);
      check($sformatf("R2-R8 vec%0d B", v), rb_data, VEC[v][7:0]);
    end

    // R7: no forwarding before the edge, new value right after
    @(negedge clk);
    wa_en = 1'b1; wa_sel = 4'h1; wa_data = 8'h99; wb_en = 1'b0;
    ra_sel = 4'h1; rb_sel = 4'h1;
    #1;
    check("R7 old value before edge", ra_data, 8'h34);
    @(posedge clk); #2;
    check("R7 new value after edge", ra_data, 8'h99);
    check("R8 both ports same reg", rb_data, 8'h99);

    // R9: reset beats active writes
    @(negedge clk);
    rst = 1'b1;
    wa_en = 1'b1; wa_sel = 4'h2; wa_data = 8'h11;
    wb_en = 1'b1; wb_sel = 4'h3; wb_data = 8'h22;
    @(posedge clk); #2;
    @(negedge clk);
    rst = 1'b0; wa_en = 1'b0; wb_en = 1'b0;
    ra_sel = 4'h2; rb_sel = 4'h3;
    #1;
    check("R9 write target A cleared", ra_data, 8'h00);
    check("R9 write target B cleared", rb_data, 8'h00);
    ra_sel = 4'h0; rb_sel = 4'hF;
    #1;
    check("R1 reg0 cleared", ra_data, 8'h00);
    check("R1 reg15 cleared", rb_data, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule